// File: doc/BRIEF.md
# Timer-Paced Serial DAC Frame Generator

This block is a serial master that feeds 16-bit samples to a serial-input DAC at a fixed, programmable sample rate. A free-running timer sets the sample period. On each timer tick the block offers a one-cycle ready on a ready/valid sample input, takes the waiting word, and sends it as one frame: an active-low framing signal held low for exactly sixteen bit clocks, a bit clock, its inverse used as the DAC chip select (the DAC samples data on the chip-select rising edge), and serial data, most significant bit first.

One bit clock after the framing signal returns high, the block raises a load strobe for one full bit clock. The load strobe is therefore tied to the timer and not to software timing, so every DAC output update lands exactly one sample period after the previous one. If no sample is waiting at a tick, the previous word is sent again and an underrun flag is raised for that frame.

Both the sample period (in system clocks) and the bit-clock divider can be changed at run time. The period is automatically stretched to the shortest legal value for the current divider, and the divider is captured at the start of each frame so a change never disturbs a frame in flight.

Top module: `dac_frame_pacer`

## Requirements
- R1: Consecutive falling edges of `frame_n_o` are exactly max(P, 36*(D+1)+1) system clocks apart, where P is `period_i` and D is `bdiv_i`; a tick and the next frame start are separated by one clock (`frame_n_o` falls in the cycle after `smp_ready_o` is high).
- R2: `frame_n_o` stays low for exactly 32*(D+1) clocks per frame (sixteen bit clocks, each half bit clock lasting D+1 clocks), and `bclk_o` is low whenever `frame_n_o` is high.
- R3: During and straight after reset `frame_n_o`=1, `bclk_o`=0, `csel_o`=1, `load_o`=0, `underrun_o`=0 and `smp_ready_o`=0; before any sample is accepted the resent word is 0x0000.
- R4: `csel_o` is always the inverse of `bclk_o`; `sdata_o` is stable at every rising edge of `csel_o`, and the sixteen bits captured at those edges, in order, equal the frame's word with bit 15 first.
- R5: `load_o` rises exactly 2*(D+1) clocks after `frame_n_o` rises, stays high for exactly 2*(D+1) clocks, and is never high while `frame_n_o` is low.
- R6: `msb_first_o` is constantly 1, selecting most-significant-bit-first order at the DAC.
- R7: The divider is captured at the tick that starts a frame; a change to `bdiv_i` or `period_i` made during a frame leaves that frame's timing untouched and applies from the next tick.
- R8: If `smp_valid_i` is low at a tick, the last accepted word is sent again and `underrun_o` is 1 from the frame start until the next tick; a tick with `smp_valid_i` high sets `underrun_o` to 0.
- R9: `smp_ready_o` is high for exactly one clock per tick and only while no frame or load strobe is active; a waiting valid sample is not consumed between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 16 | Sample period in system clocks |
| bdiv_i | input | 8 | Half bit-clock length minus one, in system clocks |
| smp_data_i | input | 16 | Sample word |
| smp_valid_i | input | 1 | Sample word is valid |
| smp_ready_o | output | 1 | Sample accepted this cycle (one pulse per tick) |
| frame_n_o | output | 1 | Active-low word framing |
| bclk_o | output | 1 | Serial bit clock |
| csel_o | output | 1 | DAC chip select, inverse of the bit clock |
| sdata_o | output | 1 | Serial data, MSB first |
| load_o | output | 1 | DAC load strobe |
| msb_first_o | output | 1 | Bit-order select, held high |
| underrun_o | output | 1 | Current frame repeats the previous word |

## Verification
The hardest situation to reach from the ports is a configuration change that lands while a frame is still shifting: the frame must keep the divider it started with while the timer already counts toward a period derived from the new values. The stimulus changes period and divider one or two clocks after each observed frame start in a randomized phase, choosing the new period no shorter than the frame still in flight, and the bench measures each frame against the divider recorded at its own tick. Underruns are produced by withholding valid across several ticks after the last held sample drains, so repeated words and the flag's clear on recovery are both observed.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_GAP   = 2'd2,
    SQ_LOAD  = 2'd3
  } seq_state_t;

  // Clocks one frame occupies: word bits plus gap plus load, two halves each,
  // plus one cycle so the sequencer is idle again at the next tick.
  function automatic int unsigned busy_cycles(input int unsigned half_m1,
                                              input int unsigned word_w);
    return 2 * (word_w + 2) * (half_m1 + 1) + 1;
  endfunction

  function automatic int unsigned eff_period(input int unsigned per,
                                             input int unsigned half_m1,
                                             input int unsigned word_w);
    int unsigned floor_v;
    floor_v = busy_cycles(half_m1, word_w);
    return (per >= floor_v) ? per : floor_v;
  endfunction

endpackage

// File: rtl/dfp_timer.sv
module dfp_timer #(
  parameter int PER_W = 16,
  parameter int DIV_W = 8,
  parameter int W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  import dfp_pkg::*;

  localparam int CNT_W = PER_W + 1;

  logic [CNT_W-1:0] cnt_q;
  int unsigned      limit;

  always_comb begin
    limit  = eff_period(32'(period_i), 32'(div_i), W) - 1;
    tick_o = (32'(cnt_q) >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dfp_sample_hold.sv
module dfp_sample_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o,
  output logic         underrun_o
);
  logic [W-1:0] held_q;

  assign word_o = valid_i ? data_i : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= '0;
      underrun_o <= 1'b0;
    end else if (accept_i) begin
      held_q     <= word_o;
      underrun_o <= ~valid_i;
    end
  end
endmodule

// File: rtl/dfp_serializer.sv
module dfp_serializer #(
  parameter int W     = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [W-1:0]     word_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic [DIV_W-1:0] div_act_o,
  output logic             frame_n_o,
  output logic             bclk_o,
  output logic             sdata_o,
  output logic             load_o
);
  import dfp_pkg::*;

  localparam int BIT_W = $clog2(W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  seq_state_t       st_q;
  logic [DIV_W-1:0] hc_q;
  logic             half_q;
  logic [BIT_W-1:0] bit_q;
  logic [W-1:0]     sh_q;
  logic             half_end;

  assign half_end  = (hc_q == div_act_o);
  assign busy_o    = (st_q != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      hc_q      <= '0;
      half_q    <= 1'b0;
      bit_q     <= '0;
      sh_q      <= '0;
      div_act_o <= '0;
      frame_n_o <= 1'b1;
      bclk_o    <= 1'b0;
      sdata_o   <= 1'b0;
      load_o    <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            div_act_o <= div_i;
            sh_q      <= {word_i[W-2:0], 1'b0};
            sdata_o   <= word_i[W-1];
            bclk_o    <= 1'b1;
            frame_n_o <= 1'b0;
            hc_q      <= '0;
            half_q    <= 1'b0;
            bit_q     <= '0;
            st_q      <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          if (half_end) begin
            hc_q <= '0;
            if (!half_q) begin
              half_q <= 1'b1;
              bclk_o <= 1'b0;
            end else begin
              half_q <= 1'b0;
              if (bit_q == LAST_BIT) begin
                frame_n_o <= 1'b1;
                st_q      <= SQ_GAP;
              end else begin
                bit_q   <= bit_q + 1'b1;
                bclk_o  <= 1'b1;
                sdata_o <= sh_q[W-1];
                sh_q    <= {sh_q[W-2:0], 1'b0};
              end
            end
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end
        SQ_GAP, SQ_LOAD: begin
          if (half_end) begin
            hc_q   <= '0;
            half_q <= ~half_q;
            if (half_q) begin
              if (st_q == SQ_GAP) begin
                load_o <= 1'b1;
                st_q   <= SQ_LOAD;
              end else begin
                load_o <= 1'b0;
                st_q   <= SQ_IDLE;
              end
            end
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_frame_pacer.sv
module dac_frame_pacer #(
  parameter int W     = 16,
  parameter int PER_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  input  logic [DIV_W-1:0] bdiv_i,
  input  logic [W-1:0]     smp_data_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  output logic             frame_n_o,
  output logic             bclk_o,
  output logic             csel_o,
  output logic             sdata_o,
  output logic             load_o,
  output logic             msb_first_o,
  output logic             underrun_o
);
  logic             tick_w;
  logic             busy_w;
  logic             accept_w;
  logic [W-1:0]     word_w;
  logic [DIV_W-1:0] div_act_w;

  assign accept_w    = tick_w & ~busy_w;
  assign smp_ready_o = accept_w;
  assign csel_o      = ~bclk_o;
  assign msb_first_o = 1'b1;

  dfp_timer #(.PER_W(PER_W), .DIV_W(DIV_W), .W(W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .div_i    (bdiv_i),
    .tick_o   (tick_w)
  );

  dfp_sample_hold #(.W(W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept_w),
    .valid_i    (smp_valid_i),
    .data_i     (smp_data_i),
    .word_o     (word_w),
    .underrun_o (underrun_o)
  );

  dfp_serializer #(.W(W), .DIV_W(DIV_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (accept_w),
    .word_i    (word_w),
    .div_i     (bdiv_i),
    .busy_o    (busy_w),
    .div_act_o (div_act_w),
    .frame_n_o (frame_n_o),
    .bclk_o    (bclk_o),
    .sdata_o   (sdata_o),
    .load_o    (load_o)
  );
endmodule

// File: rtl/dfp_checks.sv
module dfp_checks #(
  parameter int W     = 16,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             valid,
  input logic             frame_n,
  input logic             bclk,
  input logic             csel,
  input logic             sdata,
  input logic             load,
  input logic             underrun,
  input logic [DIV_W-1:0] div_act
);
  logic [31:0] low_run;
  logic [31:0] high_run;

  function automatic logic [31:0] halves(input int unsigned n, input logic [DIV_W-1:0] d);
    return 32'(n) * (32'(d) + 32'd1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= frame_n ? 32'd0 : low_run + 32'd1;
      high_run <= frame_n ? high_run + 32'd1 : 32'd0;
    end
  end

  a_r1_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !frame_n);
  a_r2_frame_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> (low_run == halves(2 * W, div_act)));
  a_r2_no_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |-> !bclk);
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csel) |-> $stable(sdata));
  a_r5_load_outside: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> frame_n);
  a_r5_load_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load) |-> (high_run == halves(2, div_act)));
  a_r8_under_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !valid) |=> underrun);
  a_r8_under_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && valid) |=> !underrun);
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (frame_n && !load));
  a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
endmodule

bind dac_frame_pacer dfp_checks #(.W(W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (smp_ready_o),
  .valid    (smp_valid_i),
  .frame_n  (frame_n_o),
  .bclk     (bclk_o),
  .csel     (csel_o),
  .sdata    (sdata_o),
  .load     (load_o),
  .underrun (underrun_o),
  .div_act  (div_act_w)
);

// File: tb/dac_frame_pacer_bench.sv
module dac_frame_pacer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period_i;
  logic [7:0]  bdiv_i;
  logic [15:0] smp_data_i = 16'h0;
  logic        smp_valid_i = 1'b0;
  logic        smp_ready_o, frame_n_o, bclk_o, csel_o, sdata_o, load_o;
  logic        msb_first_o, underrun_o;

  int unsigned period_v = 50;
  int unsigned div_v    = 0;
  bit          src_en   = 1'b1;
  bit          done     = 1'b0;
  int          checks   = 0;
  int          errors   = 0;

  always #2 clk = ~clk;
  assign period_i = 16'(period_v);
  assign bdiv_i   = 8'(div_v);

  dac_frame_pacer u_dac_frame_pacer (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .bdiv_i(bdiv_i),
    .smp_data_i(smp_data_i), .smp_valid_i(smp_valid_i), .smp_ready_o(smp_ready_o),
    .frame_n_o(frame_n_o), .bclk_o(bclk_o), .csel_o(csel_o), .sdata_o(sdata_o),
    .load_o(load_o), .msb_first_o(msb_first_o), .underrun_o(underrun_o)
  );

  function automatic int unsigned exp_gap(input int unsigned p, input int unsigned d);
    int unsigned need;
    need = 36 * d + 37;
    if (p < need) return need;
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and sample source, all at the falling edge
  int          cyc = 0, nfr = 0, nready = 0;
  int          last_fall = 0, rise_t = 0, ld_t = 0, nbits = 0;
  bit          have_fall = 0;
  bit          p_fn = 1, p_cs = 1, p_ld = 0, p_rdy = 0, consumed = 0;
  logic [15:0] bits = 0, last_word = 0, q_word = 0, f_word = 0;
  bit          q_under = 0, f_under = 0;
  int unsigned q_div = 0, f_div = 0;
  int          inv_err = 0, idle_err = 0, msb_err = 0, dbl_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (csel_o == bclk_o) inv_err++;
      if (frame_n_o && bclk_o) idle_err++;
      if (!msb_first_o) msb_err++;
      if (smp_ready_o) begin
        nready++;
        if (p_rdy) dbl_err++;
        q_word    = smp_valid_i ? smp_data_i : last_word;
        last_word = q_word;
        q_under   = !smp_valid_i;
        q_div     = div_v;
        consumed  = smp_valid_i;
      end
      if (p_fn && !frame_n_o) begin
        nfr++;
        if (have_fall)
          chk(cyc - last_fall == int'(exp_gap(period_v, div_v)), "R1 frame interval",
              cyc - last_fall, int'(exp_gap(period_v, div_v)));
        have_fall = 1;
        last_fall = cyc;
        f_word = q_word; f_under = q_under; f_div = q_div;
        nbits = 0;
        chk(underrun_o == f_under, "R8 underrun flag", int'(underrun_o), int'(f_under));
      end
      if (!frame_n_o && !p_cs && csel_o) begin
        bits = {bits[14:0], sdata_o};
        nbits++;
      end
      if (!p_fn && frame_n_o) begin
        rise_t = cyc;
        chk(cyc - last_fall == int'(32 * (f_div + 1)), "R2/R7 frame low length",
            cyc - last_fall, int'(32 * (f_div + 1)));
        chk(nbits == 16 && bits == f_word, "R4 serial word MSB first",
            int'(bits), int'(f_word));
      end
      if (!p_ld && load_o)
        chk(cyc - rise_t == int'(2 * (f_div + 1)), "R5 load delay",
            cyc - rise_t, int'(2 * (f_div + 1)));
      if (!p_ld && load_o) ld_t = cyc;
      if (p_ld && !load_o)
        chk(cyc - ld_t == int'(2 * (f_div + 1)), "R5 load width",
            cyc - ld_t, int'(2 * (f_div + 1)));
      if (!smp_ready_o && (consumed || !smp_valid_i)) begin
        consumed    = 0;
        smp_valid_i = src_en;
        if (src_en) smp_data_i = 16'($urandom);
      end
      p_fn = frame_n_o; p_cs = csel_o; p_ld = load_o; p_rdy = smp_ready_o;
    end
  end

  task automatic set_cfg(input int unsigned p, input int unsigned d, input bit en);
    @(posedge clk); #1;
    period_v = p; div_v = d; src_en = en;
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(frame_n_o == 1'b1, "R3 reset frame_n", int'(frame_n_o), 1);
    chk(bclk_o == 1'b0 && csel_o == 1'b1, "R3 reset bclk/csel", int'(bclk_o), 0);
    chk(load_o == 1'b0 && underrun_o == 1'b0, "R3 reset load/underrun", int'(load_o), 0);
    chk(smp_ready_o == 1'b0, "R3 reset ready", int'(smp_ready_o), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    wait (nfr >= 6);
    set_cfg(10, 1, 1);            // R1 clamp: period below the floor for D=1
    wait (nfr >= 11);
    set_cfg(80, 0, 0);            // R8 starve the source
    wait (nfr >= 16);
    set_cfg(80, 0, 1);
    wait (nfr >= 19);
    for (int i = 0; i < 8; i++) begin
      int unsigned d_new, p_new, floor_old;
      floor_old = 36 * (div_v + 1) + 1;
      d_new = $urandom % 4;
      p_new = 30 + $urandom % 150;
      if (p_new < floor_old) p_new = floor_old;
      set_cfg(p_new, d_new, ($urandom % 3) != 0);   // R7 change during a frame
      wait (nfr >= 21 + 2 * i);
    end
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk(inv_err == 0, "R4 csel inverse of bclk", inv_err, 0);
    chk(idle_err == 0, "R2 bclk quiet outside frame", idle_err, 0);
    chk(msb_err == 0, "R6 msb_first held high", msb_err, 0);
    chk(dbl_err == 0, "R9 ready single cycle", dbl_err, 0);
    chk(nready == nfr, "R9 one accept per frame", nready, nfr);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", nfr, 35);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule